// File: doc/BRIEF.md
# Bus Activity Capture Recorder

This block records the activity of a parallel bus made of general control lines (interrupt and DMA request or acknowledge lines among them), active-low read and write strobes, a small address field and a data byte. All bus inputs first pass through two-flop synchronisers. Records go into a small first-in first-out capture memory. A host drains that memory through a pop port that shows the oldest record.

Two capture modes exist. In continuous mode (mode = 0) the block samples the whole synchronised bus once every DIV core clocks. This gives a fixed sample rate below the core clock, and a divide by seven turns a 250 MHz core into about 35 MHz. Each sample carries a 32-bit sample-count timestamp. A sample is kept only when it differs from the previous sample, so the memory fills only on signal changes and the timing of each edge can be read back. In transaction mode (mode = 1) the block writes one record per completed bus access, taken at the rising (trailing) edge of the read or write strobe.

A one-cycle `arm` pulse starts a capture and restarts the timestamp. A one-cycle `clear` pulse stops capture, empties the memory and drops the overflow flag.

Top module: `bus_capture`

## Requirements
- R1: After reset the memory is empty (`empty`=1), `full`=0, `overflow`=0, and the block is not capturing.
- R2: In continuous mode, once armed, the synchronised bus is sampled every DIV clocks. A stored record has the timestamp in bits [REC_W-1:FRAME_W] and the frame in bits [FRAME_W-1:0]. The frame, from most to least significant, is {sig_in, rd_n, wr_n, addr_in, data_in}. A bus value applied before the clock edge that ends sample period m is captured in the sample of period m.
- R3: The timestamp counts sample periods. It restarts at 0 on `arm`, so the first sample after arming carries timestamp 0.
- R4: A sample equal to the previous sample is not stored. The first sample after each `arm` is always stored.
- R5: In transaction mode each rising edge of the synchronised read strobe or write strobe stores exactly one record. Bits [7:0] hold the data, bits [ADDR_W+7:8] the address and bit ADDR_W+8 the direction (1 = write, 0 = read). All upper bits are zero.
- R6: `full` is 1 while DEPTH records are held. A record arriving while full is dropped and sets `overflow`, which stays set until `clear`.
- R7: `clear` empties the memory, drops `overflow` and stops capture until the next `arm`.
- R8: While `empty`=0, `rd_data` shows the oldest record and `rd_en` removes it, so records come out in arrival order.
- R9: No record is stored before the first `arm`, whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 1 | 0 = continuous sampling, 1 = per-access records |
| arm | input | 1 | Pulse: start capture, restart timestamp |
| clear | input | 1 | Pulse: stop capture, empty memory, drop overflow |
| sig_in | input | SIG_W | Monitored control lines |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| addr_in | input | ADDR_W | Bus address |
| data_in | input | 8 | Bus data |
| rd_en | input | 1 | Pop the oldest record |
| rd_data | output | REC_W | Oldest record |
| empty | output | 1 | Memory holds no record |
| full | output | 1 | Memory holds DEPTH records |
| overflow | output | 1 | Sticky: a record was dropped |

## Verification
Continuous mode is driven with bus values held for different numbers of sample periods, and with one value repeated. This checks both where a change lands in the timestamp and whether duplicates are dropped. Re-arming on an unchanged bus shows that the first sample is always stored and that the timestamp starts again at zero. Transaction mode is driven with a read and a write, which checks the direction bit and the field layout. A burst of more writes than the memory holds checks the drop behaviour, the sticky overflow flag and the stop that follows a clear.

// File: rtl/bus_capture.sv
module bus_capture #(
  parameter int SIG_W  = 4,
  parameter int ADDR_W = 3,
  parameter int DIV    = 7,
  parameter int DEPTH  = 8,
  parameter int TS_W   = 32,
  localparam int FRAME_W = SIG_W + ADDR_W + 10,
  localparam int REC_W   = TS_W + FRAME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode,
  input  logic              arm,
  input  logic              clear,
  input  logic [SIG_W-1:0]  sig_in,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        data_in,
  input  logic              rd_en,
  output logic [REC_W-1:0]  rd_data,
  output logic              empty,
  output logic              full,
  output logic              overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int RD_BIT = ADDR_W + 9;
  localparam int WR_BIT = ADDR_W + 8;

  logic [FRAME_W-1:0] s1, s2, last;
  logic               have_last, armed, prev_rd, prev_wr;
  logic [CW-1:0]      cnt;
  logic [TS_W-1:0]    ts;
  logic [REC_W-1:0]   mem [DEPTH];
  logic [PW-1:0]      wptr, rptr;
  logic [PW:0]        count;

  wire live      = armed && !arm && !clear;
  wire tick      = live && !mode && (cnt == CW'(DIV - 1));
  wire cont_push = tick && (!have_last || s2 != last);
  wire rd_rise   = s2[RD_BIT] && !prev_rd;
  wire wr_rise   = s2[WR_BIT] && !prev_wr;
  wire txn_push  = live && mode && (rd_rise || wr_rise);
  wire push_req  = cont_push || txn_push;
  wire pop       = rd_en && !empty && !clear;
  wire do_write  = push_req && !full;

  wire [REC_W-1:0] rec = mode
    ? {{(REC_W-ADDR_W-9){1'b0}}, wr_rise, s2[ADDR_W+7:0]}
    : {ts, s2};

  assign empty   = (count == 0);
  assign full    = (count == (PW+1)'(DEPTH));
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      prev_rd <= 1'b1;
      prev_wr <= 1'b1;
    end else begin
      s1 <= {sig_in, rd_n, wr_n, addr_in, data_in};
      s2 <= s1;
      prev_rd <= s2[RD_BIT];
      prev_wr <= s2[WR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      armed <= 1'b0;
      have_last <= 1'b0;
      cnt <= '0;
      ts <= '0;
      last <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      have_last <= 1'b0;
      cnt <= '0;
      ts <= '0;
    end else if (armed) begin
      cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(DIV - 1)) ts <= ts + 1'b1;
      if (tick) begin
        last <= s2;
        have_last <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr <= '0;
      rptr <= '0;
      count <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_write) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)      rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + (do_write ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
      if (push_req && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (do_write) mem[wptr] <= rec;

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear |=> overflow);
  a_r6_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_req && !rd_en && !clear |=> full && overflow);
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty && !overflow && !armed);
  a_r3_ts_restart: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !clear |=> ts == '0);
  a_r8_pop_moves_head: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !empty && !clear && !push_req |=> count == $past(count) - 1'b1);
  always_comb a_r6_count_bound: assert (count <= (PW+1)'(DEPTH));
endmodule

// File: tb/bus_capture_tb.sv
`timescale 1ns/1ps
module bus_capture_tb;
  localparam int SIG_W = 4, ADDR_W = 3, DIV = 7, DEPTH = 8, TS_W = 32;
  localparam int FRAME_W = SIG_W + ADDR_W + 10;
  localparam int REC_W = TS_W + FRAME_W;

  logic clk = 0, rst_n = 0, mode = 0, arm = 0, clear = 0;
  logic [SIG_W-1:0] sig_in = '0;
  logic rd_n = 1, wr_n = 1;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [7:0] data_in = '0;
  logic rd_en = 0;
  logic [REC_W-1:0] rd_data;
  logic empty, full, overflow;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [REC_W-1:0] q[$];
  logic [FRAME_W-1:0] exp_last;
  bit exp_have;
  int period;

  always #2.5 clk = ~clk;

  bus_capture #(.SIG_W(SIG_W), .ADDR_W(ADDR_W), .DIV(DIV), .DEPTH(DEPTH), .TS_W(TS_W)) u_dut (
    .clk, .rst_n, .mode, .arm, .clear, .sig_in, .rd_n, .wr_n, .addr_in, .data_in,
    .rd_en, .rd_data, .empty, .full, .overflow);

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor side: pop records and compare with queued expectations (R8 order)
  task automatic drain(string req);
    int guard = 0;
    @(negedge clk);
    while (!empty && guard < 4 * DEPTH) begin
      if (q.size() == 0) check(0, req, rd_data, 0);
      else begin
        logic [REC_W-1:0] e = q.pop_front();
        check(rd_data == e, req, rd_data, e);
      end
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      guard++;
    end
    check(q.size() == 0, {req, " missing records"}, q.size(), 0);
    q.delete();
  endtask

  // driver side for continuous mode: apply a frame, hold it n periods
  task automatic cont_hold(logic [SIG_W-1:0] s, logic [ADDR_W-1:0] a, logic [7:0] d, int n);
    logic [FRAME_W-1:0] f = {s, 1'b1, 1'b1, a, d};
    sig_in = s; addr_in = a; data_in = d;
    if (!exp_have || f != exp_last) begin
      q.push_back({TS_W'(period), f});
      exp_last = f;
      exp_have = 1;
    end
    repeat (DIV * n) @(negedge clk);
    period += n;
  endtask

  task automatic strobe(bit wr, logic [ADDR_W-1:0] a, logic [7:0] d, bit expect_rec);
    addr_in = a; data_in = d;
    if (wr) wr_n = 0; else rd_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1; rd_n = 1;
    repeat (4) @(negedge clk);
    if (expect_rec) q.push_back({{(REC_W-ADDR_W-9){1'b0}}, wr, a, d});
  endtask

  task automatic pulse_arm();
    arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic pulse_clear();
    clear = 1; @(negedge clk); clear = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(empty == 1, "R1 empty", empty, 1);
    check(full == 0, "R1 full", full, 0);
    check(overflow == 0, "R1 overflow", overflow, 0);

    // R9: bus activity before arming
    sig_in = 4'h9; rd_n = 0; repeat (5) @(negedge clk); rd_n = 1;
    repeat (20) @(negedge clk);
    check(empty == 1, "R9 nothing before arm", empty, 1);

    // R2/R3/R4 continuous capture with a repeated value
    mode = 0; period = 0; exp_have = 0;
    sig_in = 4'h3; addr_in = 3'd1; data_in = 8'h11;
    arm = 1; @(negedge clk); arm = 0;
    repeat (DIV * 3 - 1) @(negedge clk);
    q.push_back({TS_W'(0), {4'h3, 1'b1, 1'b1, 3'd1, 8'h11}});
    exp_last = {4'h3, 1'b1, 1'b1, 3'd1, 8'h11}; exp_have = 1; period = 3;
    cont_hold(4'hA, 3'd5, 8'hC3, 2);
    cont_hold(4'hA, 3'd5, 8'hC3, 2);   // R4 repeat, no record
    cont_hold(4'h0, 3'd7, 8'h01, 1);
    cont_hold(4'h3, 3'd1, 8'h11, 3);
    drain("R2 R3 R4 continuous");

    // R3/R4: re-arm on an unchanged bus, first sample stored at ts 0
    pulse_arm();
    repeat (DIV * 2) @(negedge clk);
    q.push_back({TS_W'(0), {4'h3, 1'b1, 1'b1, 3'd1, 8'h11}});
    drain("R3 R4 rearm");

    // R5 transaction mode
    pulse_clear();
    mode = 1;
    pulse_arm();
    strobe(0, 3'd2, 8'h5A, 1);
    strobe(1, 3'd6, 8'hA7, 1);
    drain("R5 transaction");

    // R6 overflow
    for (int i = 0; i < DEPTH + 2; i++) strobe(1, 3'(i), 8'(i * 17), i < DEPTH);
    check(full == 1, "R6 full", full, 1);
    check(overflow == 1, "R6 overflow set", overflow, 1);
    drain("R6 R8 kept records");
    check(overflow == 1, "R6 overflow sticky", overflow, 1);

    // R7 clear
    pulse_clear();
    check(overflow == 0, "R7 overflow cleared", overflow, 0);
    check(empty == 1, "R7 empty", empty, 1);
    strobe(0, 3'd4, 8'h44, 0);
    check(empty == 1, "R7 stopped after clear", empty, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule